// File: doc/BRIEF.md
# Dual-Width Static RAM Array

A synchronous on-chip memory that a host can address either as 16-bit words or as 8-bit bytes, with the choice made cycle by cycle through a mode input. Two chip-select inputs of opposite polarity must both be active before anything happens. An output-enable input and a read/write input pick the operation, and two active-low lane controls gate the low and high byte of the bus independently, for reads as well as for writes.

The bus is split into a data-in vector, a data-out vector and a per-bit drive-enable vector, so a pad ring can turn it into a tristate bus. In byte mode the most significant data-in pin is no longer data. It serves as the lowest address bit and picks which half of the addressed word is touched, while only the low eight data pins carry the byte. Storage is one array of words, so data written in one mode can be read in the other. Inputs are sampled on the rising clock edge. A write lands at that edge, and read data and drive enables appear from registers one cycle later.

Top module: `dual_width_sram`

## Requirements
- R1: The block is selected only when `sel_n` is 0 and `sel` is 1. In any other combination nothing is written, and one cycle later `dq_oe` is all zeros.
- R2: A word-mode write (`wide`=1, `rw`=0, selected) stores `dq_in[7:0]` into bits 7:0 of word `addr` only if `lo_n`=0, and stores `dq_in[15:8]` into bits 15:8 only if `hi_n`=0. A lane whose control is 1 keeps its old contents.
- R3: A word-mode read (`wide`=1, `rw`=1, `oe_n`=0, selected) sets `dq_oe[7:0]` to 0xFF when `lo_n`=0 and `dq_oe[15:8]` to 0xFF when `hi_n`=0, one cycle later. Each enabled lane carries the stored byte on `dq_out`. A lane that is not enabled reads 0 on `dq_out` and 0 on `dq_oe`.
- R4: When the block is selected for reading with `oe_n`=1, or in word mode with both `lo_n` and `hi_n` at 1, `dq_oe` is all zeros one cycle later.
- R5: During a write cycle, `dq_oe` is all zeros one cycle later, whatever the value of `oe_n`.
- R6: A byte-mode write (`wide`=0) uses `dq_in[15]` as the half select. A 0 writes `dq_in[7:0]` into bits 7:0 of word `addr`, and a 1 writes it into bits 15:8. The other half is unchanged, and `lo_n`/`hi_n` have no effect.
- R7: A byte-mode read returns bits 7:0 of the word (when `dq_in[15]`=0) or bits 15:8 (when `dq_in[15]`=1) on `dq_out[7:0]` one cycle later, with `dq_oe`=0x00FF and `dq_out[15:8]`=0. `lo_n`/`hi_n` have no effect.
- R8: While and right after `rst` is 1, `dq_oe` and `dq_out` are all zeros.
- R9: Both modes share one storage array. A word written in word mode reads back as its two halves in byte mode, and bytes written in byte mode read back as one combined word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output control |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| oe_n | input | 1 | Active-low output enable |
| rw | input | 1 | 1 = read, 0 = write |
| wide | input | 1 | 1 = 16-bit word mode, 0 = 8-bit byte mode |
| lo_n | input | 1 | Active-low low-lane control (word mode) |
| hi_n | input | 1 | Active-low high-lane control (word mode) |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data in; bit 15 is the half select in byte mode |
| dq_out | output | 16 | Registered read data |
| dq_oe | output | 16 | Per-bit drive enable for the bus |

## Verification
The hardest situation to reach is the one where the same storage word is touched in both widths. A byte-mode write must reach exactly one half, chosen by a pin that in word mode is ordinary data. This has to be told apart from a design that uses the lane controls or writes both halves. The stimulus therefore writes a known word in word mode, overwrites a single half in byte mode with both lane controls held inactive, and reads the result back both as a full word and as each half. A reference array inside the bench predicts every read.

// File: rtl/dwsram_pkg.sv
package dwsram_pkg;
  localparam int LANES = 2;

  typedef struct packed {
    logic             narrow;
    logic             half;
    logic [LANES-1:0] lanes;
  } rd_ctrl_t;
endpackage

// File: rtl/dwsram_decode.sv
module dwsram_decode
  import dwsram_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                      ce_lo_n,
  input  logic                      ce_hi,
  input  logic                      oe_n,
  input  logic                      rw,
  input  logic                      wide,
  input  logic                      lo_n,
  input  logic                      hi_n,
  input  logic [LANE_W*LANES-1:0]   dq_in,
  output logic [LANES-1:0]          wr_be,
  output logic [LANE_W*LANES-1:0]   wr_data,
  output rd_ctrl_t                  rctl
);
  localparam int DW = LANE_W * LANES;

  logic chosen, do_wr, do_rd, half;
  logic [LANES-1:0] lane_req;

  assign chosen   = !ce_lo_n && ce_hi;
  assign do_wr    = chosen && !rw;
  assign do_rd    = chosen && rw && !oe_n;
  assign half     = dq_in[DW-1];
  assign lane_req = {!hi_n, !lo_n};

  always_comb begin
    rctl = '0;
    if (wide) begin
      wr_be      = do_wr ? lane_req : '0;
      wr_data    = dq_in;
      rctl.lanes = do_rd ? lane_req : '0;
    end else begin
      wr_be       = do_wr ? (half ? 2'b10 : 2'b01) : 2'b00;
      wr_data     = {LANES{dq_in[LANE_W-1:0]}};
      rctl.narrow = 1'b1;
      rctl.half   = half;
      rctl.lanes  = do_rd ? 2'b01 : 2'b00;
    end
  end
endmodule

// File: rtl/dwsram_array.sv
module dwsram_array
  import dwsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        wr_be,
  input  logic [LANE_W*LANES-1:0] wr_data,
  output logic [LANE_W*LANES-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_be[g]) store[addr] <= wr_data[g*LANE_W +: LANE_W];
      rd_q <= store[addr];
    end

    assign rd_data[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/dwsram_drive.sv
module dwsram_drive
  import dwsram_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  rd_ctrl_t                rctl,
  input  logic [LANE_W*LANES-1:0] rd_data,
  output logic [LANE_W*LANES-1:0] dq_out,
  output logic [LANE_W*LANES-1:0] dq_oe
);
  rd_ctrl_t ctl_q;

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= rctl;
  end

  always_comb begin
    dq_out = '0;
    dq_oe  = '0;
    if (ctl_q.narrow) begin
      dq_oe[LANE_W-1:0] = {LANE_W{ctl_q.lanes[0]}};
      if (ctl_q.lanes[0])
        dq_out[LANE_W-1:0] = ctl_q.half ? rd_data[2*LANE_W-1:LANE_W]
                                        : rd_data[LANE_W-1:0];
    end else begin
      for (int i = 0; i < LANES; i++) begin
        dq_oe[i*LANE_W +: LANE_W] = {LANE_W{ctl_q.lanes[i]}};
        if (ctl_q.lanes[i])
          dq_out[i*LANE_W +: LANE_W] = rd_data[i*LANE_W +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/dual_width_sram.sv
module dual_width_sram
  import dwsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sel_n,
  input  logic                    sel,
  input  logic                    oe_n,
  input  logic                    rw,
  input  logic                    wide,
  input  logic                    lo_n,
  input  logic                    hi_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANE_W*LANES-1:0] dq_in,
  output logic [LANE_W*LANES-1:0] dq_out,
  output logic [LANE_W*LANES-1:0] dq_oe
);
  localparam int DW = LANE_W * LANES;

  logic [LANES-1:0] wr_be;
  logic [DW-1:0]    wr_data;
  logic [DW-1:0]    rd_data;
  rd_ctrl_t         rctl;

  dwsram_decode #(.LANE_W(LANE_W)) dec_i (
    .ce_lo_n(sel_n), .ce_hi(sel), .oe_n(oe_n), .rw(rw), .wide(wide),
    .lo_n(lo_n), .hi_n(hi_n), .dq_in(dq_in),
    .wr_be(wr_be), .wr_data(wr_data), .rctl(rctl)
  );

  dwsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) arr_i (
    .clk(clk), .addr(addr), .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data)
  );

  dwsram_drive #(.LANE_W(LANE_W)) drv_i (
    .clk(clk), .rst(rst), .rctl(rctl), .rd_data(rd_data),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );
endmodule

// File: rtl/dwsram_chk.sv
module dwsram_chk #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                sel_n,
  input logic                sel,
  input logic                oe_n,
  input logic                rw,
  input logic                wide,
  input logic                lo_n,
  input logic                hi_n,
  input logic [ADDR_W-1:0]   addr,
  input logic [2*LANE_W-1:0] dq_in,
  input logic [2*LANE_W-1:0] dq_out,
  input logic [2*LANE_W-1:0] dq_oe
);
  AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (rst)
    (sel_n || !sel) |=> (dq_oe == '0)); // R1

  AST_OE_OFF_HIZ: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && sel && rw && oe_n) |=> (dq_oe == '0)); // R4

  AST_NO_LANE_HIZ: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && sel && rw && wide && lo_n && hi_n) |=> (dq_oe == '0)); // R4

  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && sel && !rw) |=> (dq_oe == '0)); // R5

  AST_BYTE_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && sel && rw && !oe_n && !wide)
      |=> (dq_oe == {{LANE_W{1'b0}}, {LANE_W{1'b1}}})); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (dq_oe == '0 && dq_out == '0)); // R8
endmodule

bind dual_width_sram dwsram_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) chk_i (
  .clk(clk), .rst(rst), .sel_n(sel_n), .sel(sel), .oe_n(oe_n), .rw(rw),
  .wide(wide), .lo_n(lo_n), .hi_n(hi_n), .addr(addr), .dq_in(dq_in),
  .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/dual_width_sram_tb_top.sv
module dual_width_sram_tb_top;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, sel = 1'b0, oe_n = 1'b1, rw = 1'b1, wide = 1'b1;
  logic lo_n = 1'b1, hi_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, dq_oe;

  logic [15:0] ref_mem [1 << AW];
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dual_width_sram #(.ADDR_W(AW), .LANE_W(8)) dut_i (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sel(sel), .oe_n(oe_n), .rw(rw),
    .wide(wide), .lo_n(lo_n), .hi_n(hi_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one operation at a negedge; return at the next negedge, after the posedge.
  task automatic apply(input logic c1n, input logic c2, input logic oen, input logic rwi,
                       input logic wd, input logic ln, input logic hn,
                       input logic [AW-1:0] a, input logic [15:0] d);
    sel_n = c1n; sel = c2; oe_n = oen; rw = rwi; wide = wd;
    lo_n = ln; hi_n = hn; addr = a; dq_in = d;
    @(negedge clk);
  endtask

  task automatic word_write(input logic [AW-1:0] a, input logic [15:0] d,
                            input logic ln, input logic hn, input logic oen);
    apply(1'b0, 1'b1, oen, 1'b0, 1'b1, ln, hn, a, d);
    if (!ln) ref_mem[a][7:0]  = d[7:0];
    if (!hn) ref_mem[a][15:8] = d[15:8];
  endtask

  task automatic byte_write(input logic [AW-1:0] a, input logic h, input logic [7:0] b);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, a, {h, 7'h55, b});
    if (h) ref_mem[a][15:8] = b;
    else   ref_mem[a][7:0]  = b;
  endtask

  task automatic word_read(input string tag, input logic [AW-1:0] a,
                           input logic ln, input logic hn);
    logic [15:0] m;
    apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, ln, hn, a, 16'h0);
    m = {{8{!hn}}, {8{!ln}}};
    check({tag, " oe"}, dq_oe, m);
    check({tag, " data"}, dq_out, ref_mem[a] & m);
  endtask

  task automatic byte_read(input string tag, input logic [AW-1:0] a, input logic h);
    apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, a, {h, 15'h0});
    check({tag, " oe"}, dq_oe, 16'h00FF);
    check({tag, " data"}, dq_out, {8'h00, h ? ref_mem[a][15:8] : ref_mem[a][7:0]});
  endtask

  task automatic t_reset;
    check("R8 reset oe", dq_oe, 16'h0);
    check("R8 reset data", dq_out, 16'h0);
  endtask

  task automatic t_word;
    word_write(8'h01, 16'hA5C3, 1'b0, 1'b0, 1'b1);
    word_write(8'hFF, 16'h1234, 1'b0, 1'b0, 1'b1);
    word_write(8'h00, 16'hFFFF, 1'b0, 1'b0, 1'b1);
    word_read("R2 R3 full a01", 8'h01, 1'b0, 1'b0);
    word_read("R2 R3 full aFF", 8'hFF, 1'b0, 1'b0);
    word_read("R2 R3 full a00", 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_lanes;
    word_write(8'h01, 16'h0F0F, 1'b0, 1'b1, 1'b1);
    word_read("R2 low lane write", 8'h01, 1'b0, 1'b0);
    word_write(8'hFF, 16'hBEEF, 1'b1, 1'b0, 1'b1);
    word_read("R2 high lane write", 8'hFF, 1'b0, 1'b0);
    word_read("R3 low lane read", 8'hFF, 1'b0, 1'b1);
    word_read("R3 high lane read", 8'h01, 1'b1, 1'b0);
  endtask

  task automatic t_deselect;
    apply(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h01, 16'h0);
    check("R1 sel_n high read oe", dq_oe, 16'h0);
    apply(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h01, 16'h0);
    check("R1 sel low read oe", dq_oe, 16'h0);
    apply(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h01, 16'hDEAD);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h01, 16'hDEAD);
    word_read("R1 blocked writes", 8'h01, 1'b0, 1'b0);
    apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h01, 16'h0);
    check("R4 oe_n high oe", dq_oe, 16'h0);
    check("R4 oe_n high data", dq_out, 16'h0);
    word_read("R4 both lanes off", 8'h01, 1'b1, 1'b1);
  endtask

  task automatic t_write_hiz;
    word_write(8'h20, 16'h7E81, 1'b0, 1'b0, 1'b0);
    check("R5 write with oe_n low", dq_oe, 16'h0);
    word_read("R5 write landed", 8'h20, 1'b0, 1'b0);
  endtask

  task automatic t_bytes;
    word_write(8'h40, 16'hC0DE, 1'b0, 1'b0, 1'b1);
    byte_read("R7 R9 low half", 8'h40, 1'b0);
    byte_read("R7 R9 high half", 8'h40, 1'b1);
    byte_write(8'h40, 1'b1, 8'h3A);
    word_read("R6 high half only", 8'h40, 1'b0, 1'b0);
    byte_write(8'h40, 1'b0, 8'h96);
    word_read("R6 low half only", 8'h40, 1'b0, 1'b0);
    byte_write(8'h7F, 1'b0, 8'h11);
    byte_write(8'h7F, 1'b1, 8'hEE);
    byte_read("R6 R7 low back", 8'h7F, 1'b0);
    byte_read("R6 R7 high back", 8'h7F, 1'b1);
    word_read("R9 bytes as word", 8'h7F, 1'b0, 1'b0);
    apply(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h7F, 16'h8000);
    check("R7 lanes ignored oe", dq_oe, 16'h00FF);
    check("R7 lanes ignored data", dq_out, 16'h00EE);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    // clear the words the tests touch so the reference matches
    for (int i = 0; i < (1 << AW); i++) word_write(i[AW-1:0], 16'h0, 1'b0, 1'b0, 1'b1);
    t_word();
    t_lanes();
    t_deselect();
    t_write_hiz();
    t_bytes();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired, run incomplete (R1..R9 unverified)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule